// File: doc/BRIEF.md
# Block-Write and Write-Mask Engine

This block sits beside the column path of a 4-bit-wide dynamic memory write port. It produces the enables for each write. For every write it gives a group address for four adjacent columns, a column enable for each column of the group, an enable for each data lane and the data to store. Three kinds of write are supported:

- **Plain writes** store the data bus into one column on all lanes.
- **Block writes** treat the data bus as a column mask and store a held color value into up to four neighbouring columns at once.
- **Masked writes** restrict the lanes. The lane mask is taken either from the bus at the moment the row opens, or from a mask register that keeps its value between rows.

A decoder upstream sets the cycle mode. Strobe edges arrive as single-cycle event pulses, synchronous to the block clock:

- row opening (row fall)
- row closing (row rise)
- column strobe fall
- write-enable fall

The engine latches the mode when the row opens. It then waits for both the column strobe and the write enable in any order. On the later of the two it captures the bus and emits a one-cycle write pulse. Two further modes load the mask register or the color register instead of writing. A row can carry several captures (page mode).

Top module: `bwm_engine`

## Requirements
- R1: After reset all outputs are low, the persistent mask register holds all ones and the color register holds all zeros.
- R2: A capture happens in the clock cycle in which the later of the column-strobe and write-enable events arrives; both may arrive in the same cycle. For a write mode, `wr_stb_o` is high for exactly the one cycle after that clock edge. While `wr_stb_o` is low, `col_en_o`, `io_en_o`, `grp_addr_o` and `wdata_o` are all zero.
- R3: A plain write (mode 3'b000) drives `grp_addr_o` = column address bits 8..2. It enables only the column whose index equals address bits 1..0 (`col_en_o` bit n for index n), enables all four lanes, and writes the bus value present at capture.
- R4: In a block write (mode bit 0 = 1), `grp_addr_o` = column address bits 8..2, and address bits 1..0 have no effect on any output.
- R5: In a block write, `col_en_o` equals the bus value at capture (a high bit enables that column) and `wdata_o` equals the color register.
- R6: In a load-and-use masked write (mode bits 2..1 = 2'b01), `io_en_o` equals the bus value sampled in the row-fall cycle. That value does not change the persistent mask register.
- R7: In a persistent masked write (mode bits 2..1 = 2'b10), `io_en_o` equals the persistent mask register. The register keeps its value until a mask-load capture.
- R8: Mode 3'b110 stores the bus value at capture into the mask register. Mode 3'b111 stores it into the color register. Neither mode raises `wr_stb_o`.
- R9: Column-strobe and write-enable events are ignored in these cases: while no row is open, and in a cycle with a row-fall or row-rise event. A row rise or a new row fall discards a half-completed capture.
- R10: The mode is sampled in the row-fall cycle and holds for every capture until the row closes. This allows several page-mode writes in one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| row_fall_i | input | 1 | Row strobe fall event (one-cycle pulse) |
| row_rise_i | input | 1 | Row strobe rise event, closes the row |
| cyc_mode_i | input | 3 | Cycle mode from the decoder, sampled at row fall |
| col_fall_i | input | 1 | Column strobe fall event |
| col_addr_i | input | 9 | Column address, sampled with the column event |
| we_fall_i | input | 1 | Write-enable fall event |
| dq_i | input | 4 | Data bus: lane mask at row fall, data or column mask at capture |
| wr_stb_o | output | 1 | One-cycle write pulse |
| grp_addr_o | output | 7 | Address of the four-column group |
| col_en_o | output | 4 | Per-column enables inside the group |
| io_en_o | output | 4 | Per-lane write enables |
| wdata_o | output | 4 | Data to write |

## Verification
Every result of this block appears exactly one clock edge after the cycle that completes the capture. This covers the write pulse, the enables, the group address and the data. Register loads become visible from the capture after the load.

The bench drives each event half a period before a rising edge and samples the outputs at the next falling edge, which is the only cycle in which a pulse is visible. Its behavioural model updates at the same rising edge as the design, so the comparison made on every falling edge lines up with the one-edge latency.

Directed sequences check the order of the two capture events, events left pending across a row boundary, and the lasting effect of register loads on later writes. A random phase then mixes events freely.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Mode bit 0 selects block addressing; bits 2..1 pick the lane-mask source
    // or, when both set, a register-load cycle (bit 0 then picks which register).
    typedef enum logic [2:0] {
        MODE_WR_PLAIN    = 3'b000,
        MODE_BLK_PLAIN   = 3'b001,
        MODE_WR_ROWMASK  = 3'b010,
        MODE_BLK_ROWMASK = 3'b011,
        MODE_WR_PERSIST  = 3'b100,
        MODE_BLK_PERSIST = 3'b101,
        MODE_LOAD_MASK   = 3'b110,
        MODE_LOAD_COLOR  = 3'b111
    } bwm_mode_e;

    typedef enum logic [1:0] {
        MSRC_ALL     = 2'b00,
        MSRC_ROW     = 2'b01,
        MSRC_PERSIST = 2'b10,
        MSRC_LOAD    = 2'b11
    } bwm_msrc_e;

    function automatic bwm_msrc_e mask_src(input bwm_mode_e m);
        return bwm_msrc_e'(m[2:1]);
    endfunction

    function automatic logic is_block(input bwm_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/bwm_strobe_track.sv
module bwm_strobe_track
    import bwm_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int DQ_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             row_fall_i,
    input  logic             row_rise_i,
    input  bwm_mode_e        mode_i,
    input  logic             col_fall_i,
    input  logic [COL_W-1:0] col_addr_i,
    input  logic             we_fall_i,
    input  logic [DQ_W-1:0]  dq_i,
    output logic             cap_o,
    output bwm_mode_e        cap_mode_o,
    output logic [COL_W-1:0] cap_col_o,
    output logic [DQ_W-1:0]  cap_dq_o,
    output logic [DQ_W-1:0]  row_mask_o
);

    typedef struct packed {
        logic             open;
        bwm_mode_e        mode;
        logic [DQ_W-1:0]  rmask;
        logic             cas_seen;
        logic             we_seen;
        logic [COL_W-1:0] col;
    } trk_t;

    trk_t trk_d, trk_q;
    logic cas_now, we_now, cap;

    always_comb begin
        trk_d   = trk_q;
        cap     = 1'b0;
        cas_now = col_fall_i || trk_q.cas_seen;
        we_now  = we_fall_i  || trk_q.we_seen;
        if (row_fall_i) begin
            trk_d.open     = 1'b1;
            trk_d.mode     = mode_i;
            trk_d.rmask    = dq_i;
            trk_d.cas_seen = 1'b0;
            trk_d.we_seen  = 1'b0;
        end else if (row_rise_i) begin
            trk_d.open     = 1'b0;
            trk_d.cas_seen = 1'b0;
            trk_d.we_seen  = 1'b0;
        end else if (trk_q.open) begin
            if (col_fall_i) begin
                trk_d.col = col_addr_i;
            end
            if (cas_now && we_now && (col_fall_i || we_fall_i)) begin
                cap            = 1'b1;
                trk_d.cas_seen = 1'b0;
                trk_d.we_seen  = 1'b0;
            end else begin
                trk_d.cas_seen = cas_now;
                trk_d.we_seen  = we_now;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trk_q <= '{open: 1'b0, mode: MODE_WR_PLAIN, rmask: '0,
                       cas_seen: 1'b0, we_seen: 1'b0, col: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cap_o      = cap;
    assign cap_mode_o = trk_q.mode;
    assign cap_col_o  = col_fall_i ? col_addr_i : trk_q.col;
    assign cap_dq_o   = dq_i;
    assign row_mask_o = trk_q.rmask;

    AST_ROW_EDGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_fall_i || row_rise_i) |=> (!trk_q.cas_seen && !trk_q.we_seen)); // R9

    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trk_q.open && !row_fall_i) |=> $stable(trk_q.mode)); // R10

endmodule

// File: rtl/bwm_regs.sv
module bwm_regs
    import bwm_pkg::*;
#(
    parameter int DQ_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cap_i,
    input  bwm_mode_e       cap_mode_i,
    input  logic [DQ_W-1:0] cap_dq_i,
    output logic [DQ_W-1:0] mask_o,
    output logic [DQ_W-1:0] color_o
);

    typedef struct packed {
        logic [DQ_W-1:0] mask;
        logic [DQ_W-1:0] color;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ld_mask, ld_color;

    always_comb begin
        regs_d   = regs_q;
        ld_mask  = cap_i && (cap_mode_i == MODE_LOAD_MASK);
        ld_color = cap_i && (cap_mode_i == MODE_LOAD_COLOR);
        if (ld_mask) begin
            regs_d.mask = cap_dq_i;
        end
        if (ld_color) begin
            regs_d.color = cap_dq_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '{mask: '1, color: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_o  = regs_q.mask;
    assign color_o = regs_q.color;

    AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cap_i && cap_mode_i == MODE_LOAD_MASK) |=> $stable(regs_q.mask)); // R7

    AST_COLOR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cap_i && cap_mode_i == MODE_LOAD_COLOR) |=> $stable(regs_q.color)); // R8

endmodule

// File: rtl/bwm_wen_gen.sv
module bwm_wen_gen
    import bwm_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int DQ_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  bwm_mode_e        cap_mode_i,
    input  logic [COL_W-1:0] cap_col_i,
    input  logic [DQ_W-1:0]  cap_dq_i,
    input  logic [DQ_W-1:0]  row_mask_i,
    input  logic [DQ_W-1:0]  mask_i,
    input  logic [DQ_W-1:0]  color_i,
    output logic             wr_stb_o,
    output logic [COL_W-$clog2(DQ_W)-1:0] grp_addr_o,
    output logic [DQ_W-1:0]  col_en_o,
    output logic [DQ_W-1:0]  io_en_o,
    output logic [DQ_W-1:0]  wdata_o
);

    localparam int LO_W  = $clog2(DQ_W);
    localparam int GRP_W = COL_W - LO_W;

    typedef struct packed {
        logic             stb;
        logic             blk;
        logic [GRP_W-1:0] grp;
        logic [DQ_W-1:0]  col_en;
        logic [DQ_W-1:0]  io_en;
        logic [DQ_W-1:0]  data;
    } wout_t;

    wout_t out_d, out_q;
    logic [DQ_W-1:0] lane_hit;
    logic [LO_W-1:0] col_lo;
    bwm_msrc_e       src;

    assign col_lo = cap_col_i[LO_W-1:0];
    assign src    = mask_src(cap_mode_i);

    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        assign lane_hit[g] = (col_lo == LO_W'(g));
    end

    always_comb begin
        out_d = '0;
        if (cap_i && src != MSRC_LOAD) begin
            out_d.stb    = 1'b1;
            out_d.blk    = is_block(cap_mode_i);
            out_d.grp    = cap_col_i[COL_W-1:LO_W];
            out_d.col_en = out_d.blk ? cap_dq_i : lane_hit;
            out_d.data   = out_d.blk ? color_i  : cap_dq_i;
            case (src)
                MSRC_ROW:     out_d.io_en = row_mask_i;
                MSRC_PERSIST: out_d.io_en = mask_i;
                default:      out_d.io_en = '1;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign wr_stb_o   = out_q.stb;
    assign grp_addr_o = out_q.grp;
    assign col_en_o   = out_q.col_en;
    assign io_en_o    = out_q.io_en;
    assign wdata_o    = out_q.data;

    AST_PLAIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stb_o && !out_q.blk) |-> $onehot(col_en_o)); // R3

    AST_QUIET_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_stb_o |-> (col_en_o == '0 && io_en_o == '0 && wdata_o == '0)); // R2

endmodule

// File: rtl/bwm_engine.sv
module bwm_engine
    import bwm_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int DQ_W  = 4,
    localparam int GRP_W = COL_W - $clog2(DQ_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             row_fall_i,
    input  logic             row_rise_i,
    input  logic [2:0]       cyc_mode_i,
    input  logic             col_fall_i,
    input  logic [COL_W-1:0] col_addr_i,
    input  logic             we_fall_i,
    input  logic [DQ_W-1:0]  dq_i,
    output logic             wr_stb_o,
    output logic [GRP_W-1:0] grp_addr_o,
    output logic [DQ_W-1:0]  col_en_o,
    output logic [DQ_W-1:0]  io_en_o,
    output logic [DQ_W-1:0]  wdata_o
);

    logic             cap;
    bwm_mode_e        cap_mode;
    logic [COL_W-1:0] cap_col;
    logic [DQ_W-1:0]  cap_dq;
    logic [DQ_W-1:0]  row_mask;
    logic [DQ_W-1:0]  mask_q;
    logic [DQ_W-1:0]  color_q;

    bwm_strobe_track #(.COL_W(COL_W), .DQ_W(DQ_W)) u_track (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .row_fall_i (row_fall_i),
        .row_rise_i (row_rise_i),
        .mode_i     (bwm_mode_e'(cyc_mode_i)),
        .col_fall_i (col_fall_i),
        .col_addr_i (col_addr_i),
        .we_fall_i  (we_fall_i),
        .dq_i       (dq_i),
        .cap_o      (cap),
        .cap_mode_o (cap_mode),
        .cap_col_o  (cap_col),
        .cap_dq_o   (cap_dq),
        .row_mask_o (row_mask)
    );

    bwm_regs #(.DQ_W(DQ_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_i      (cap),
        .cap_mode_i (cap_mode),
        .cap_dq_i   (cap_dq),
        .mask_o     (mask_q),
        .color_o    (color_q)
    );

    bwm_wen_gen #(.COL_W(COL_W), .DQ_W(DQ_W)) u_wen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_i      (cap),
        .cap_mode_i (cap_mode),
        .cap_col_i  (cap_col),
        .cap_dq_i   (cap_dq),
        .row_mask_i (row_mask),
        .mask_i     (mask_q),
        .color_i    (color_q),
        .wr_stb_o   (wr_stb_o),
        .grp_addr_o (grp_addr_o),
        .col_en_o   (col_en_o),
        .io_en_o    (io_en_o),
        .wdata_o    (wdata_o)
    );

    AST_STB_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |-> ($past(cap) && mask_src($past(cap_mode)) != MSRC_LOAD)); // R2

    AST_LOAD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap && mask_src(cap_mode) == MSRC_LOAD) |=> !wr_stb_o); // R8

    AST_BLOCK_COLOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap && is_block(cap_mode) && mask_src(cap_mode) != MSRC_LOAD)
            |=> (wdata_o == $past(color_q))); // R5

endmodule

// File: tb/test_bwm_engine.sv
module test_bwm_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_fall = 1'b0, row_rise = 1'b0, col_fall = 1'b0, we_fall = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [8:0] col_addr = 9'd0;
    logic [3:0] dq = 4'd0;
    logic       wr_stb;
    logic [6:0] grp_addr;
    logic [3:0] col_en, io_en, wdata;

    int n_vec = 0, n_err = 0;
    bit cmp_en = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    bwm_engine i_bwm_engine (
        .clk_i(clk), .rst_ni(rst_n), .row_fall_i(row_fall), .row_rise_i(row_rise),
        .cyc_mode_i(mode), .col_fall_i(col_fall), .col_addr_i(col_addr),
        .we_fall_i(we_fall), .dq_i(dq), .wr_stb_o(wr_stb), .grp_addr_o(grp_addr),
        .col_en_o(col_en), .io_en_o(io_en), .wdata_o(wdata)
    );

    // Behavioural reference model, advanced on each rising edge.
    int m_open, m_mode, m_rmask, m_cas, m_we, m_col, m_mask, m_color;
    int e_stb, e_grp, e_col, e_io, e_dat, e_mode;

    always @(posedge clk) begin
        int col_use, src;
        bit cap;
        if (!rst_n) begin
            m_open = 0; m_mode = 0; m_rmask = 0; m_cas = 0; m_we = 0; m_col = 0;
            m_mask = 15; m_color = 0;
            e_stb = 0; e_grp = 0; e_col = 0; e_io = 0; e_dat = 0; e_mode = 0;
        end else begin
            cap = 1'b0;
            col_use = col_fall ? int'(col_addr) : m_col;
            e_stb = 0; e_grp = 0; e_col = 0; e_io = 0; e_dat = 0;
            if (row_fall) begin
                m_open = 1; m_mode = int'(mode); m_rmask = int'(dq); m_cas = 0; m_we = 0;
            end else if (row_rise) begin
                m_open = 0; m_cas = 0; m_we = 0;
            end else if (m_open != 0) begin
                if (col_fall) m_col = int'(col_addr);
                if ((col_fall || m_cas != 0) && (we_fall || m_we != 0) && (col_fall || we_fall)) begin
                    cap = 1'b1; m_cas = 0; m_we = 0;
                end else begin
                    if (col_fall) m_cas = 1;
                    if (we_fall) m_we = 1;
                end
            end
            if (cap) begin
                src = m_mode / 2;
                e_mode = m_mode;
                if (m_mode == 6) m_mask = int'(dq);
                else if (m_mode == 7) m_color = int'(dq);
                else begin
                    e_stb = 1;
                    e_grp = col_use / 4;
                    e_col = (m_mode % 2 == 1) ? int'(dq) : (1 << (col_use % 4));
                    e_dat = (m_mode % 2 == 1) ? m_color : int'(dq);
                    e_io  = (src == 1) ? m_rmask : (src == 2) ? m_mask : 15;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            n_vec++;
            if (int'(wr_stb) != e_stb) begin
                n_err++; $display("FAIL R2 stb: got %0d expected %0d", wr_stb, e_stb);
            end
            if (int'(grp_addr) != e_grp) begin
                n_err++; $display("FAIL R4 grp: got %0h expected %0h", grp_addr, e_grp);
            end
            if (int'(col_en) != e_col) begin
                n_err++; $display("FAIL %s col_en: got %0h expected %0h",
                                  (e_mode % 2 == 1) ? "R5" : "R3", col_en, e_col);
            end
            if (int'(io_en) != e_io) begin
                n_err++; $display("FAIL %s io_en: got %0h expected %0h",
                                  (e_mode / 2 == 1) ? "R6" : (e_mode / 2 == 2) ? "R7" : "R3",
                                  io_en, e_io);
            end
            if (int'(wdata) != e_dat) begin
                n_err++; $display("FAIL %s wdata: got %0h expected %0h",
                                  (e_mode % 2 == 1) ? "R5" : "R3", wdata, e_dat);
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic row_open(input logic [2:0] m, input logic [3:0] d);
        @(negedge clk); row_fall = 1'b1; mode = m; dq = d;
        @(negedge clk); row_fall = 1'b0;
    endtask

    task automatic row_close();
        @(negedge clk); row_rise = 1'b1;
        @(negedge clk); row_rise = 1'b0;
    endtask

    task automatic ev(input logic c, input logic w, input logic [8:0] a, input logic [3:0] d);
        @(negedge clk); col_fall = c; we_fall = w; col_addr = a; dq = d;
        @(negedge clk); col_fall = 1'b0; we_fall = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        chk("R1 stb in reset", int'(wr_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 col_en after reset", int'(col_en), 0);

        // R1: persistent mask starts all ones
        row_open(3'b100, 4'h0);
        ev(1, 1, 9'h005, 4'h9);
        chk("R1 mask reset value", int'(io_en), 4'hF);
        chk("R2 same-cycle capture pulse", int'(wr_stb), 1);
        @(negedge clk);
        chk("R2 pulse one cycle", int'(wr_stb), 0);
        row_close();

        // R5/R1: block write, color reset zero; CAS first then W later
        row_open(3'b001, 4'h0);
        ev(1, 0, 9'h1A7, 4'h0);
        chk("R2 no pulse before W", int'(wr_stb), 0);
        ev(0, 1, 9'h000, 4'b1011);
        chk("R5 block col mask", int'(col_en), 4'b1011);
        chk("R4 group address", int'(grp_addr), 7'h69);
        chk("R1 color reset value", int'(wdata), 0);
        row_close();

        // R8: load color, W first then CAS later
        row_open(3'b111, 4'h0);
        ev(0, 1, 9'h000, 4'h6);
        ev(1, 0, 9'h000, 4'h6);
        chk("R8 load color no pulse", int'(wr_stb), 0);
        row_close();
        // R8: load mask
        row_open(3'b110, 4'h0);
        ev(1, 1, 9'h000, 4'b0101);
        chk("R8 load mask no pulse", int'(wr_stb), 0);
        row_close();

        // R4/R7: persistent block, low address bits ignored
        row_open(3'b101, 4'h0);
        ev(1, 1, 9'h003, 4'b0110);
        chk("R4 low bits ignored grp", int'(grp_addr), 0);
        chk("R4 low bits ignored col_en", int'(col_en), 4'b0110);
        chk("R7 persistent mask", int'(io_en), 4'b0101);
        chk("R5 color data", int'(wdata), 4'h6);
        row_close();

        // R6/R10: row mask, two page-mode writes in one row
        row_open(3'b010, 4'b1001);
        ev(1, 1, 9'h102, 4'hC);
        chk("R6 row mask", int'(io_en), 4'b1001);
        chk("R3 one-hot column", int'(col_en), 4'b0100);
        ev(1, 1, 9'h103, 4'h3);
        chk("R10 mode kept page write", int'(io_en), 4'b1001);
        chk("R3 data second write", int'(wdata), 4'h3);
        row_close();
        row_open(3'b100, 4'h0);
        ev(1, 1, 9'h000, 4'h1);
        chk("R6 row mask not stored", int'(io_en), 4'b0101);
        row_close();

        // R3: plain write
        row_open(3'b000, 4'h0);
        ev(1, 1, 9'h1FF, 4'hA);
        chk("R3 plain col_en", int'(col_en), 4'b1000);
        chk("R3 plain io_en", int'(io_en), 4'hF);
        chk("R3 plain data", int'(wdata), 4'hA);
        row_close();

        // R9: closed row ignores events; row close discards pending CAS
        ev(1, 1, 9'h010, 4'hF);
        chk("R9 closed row ignored", int'(wr_stb), 0);
        row_open(3'b000, 4'h0);
        ev(1, 0, 9'h011, 4'h0);
        row_close();
        row_open(3'b000, 4'h0);
        ev(0, 1, 9'h000, 4'h5);
        chk("R9 pending discarded", int'(wr_stb), 0);
        row_close();

        // Random phase, checked by the per-cycle model comparison
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            row_fall = ($urandom_range(0, 19) == 0);
            row_rise = ($urandom_range(0, 19) == 0);
            col_fall = ($urandom_range(0, 3) == 0);
            we_fall  = ($urandom_range(0, 3) == 0);
            mode     = 3'($urandom_range(0, 7));
            col_addr = 9'($urandom_range(0, 511));
            dq       = 4'($urandom_range(0, 15));
        end
        @(negedge clk);
        row_fall = 0; row_rise = 0; col_fall = 0; we_fall = 0;
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule